// File: doc/BRIEF.md
# Flash Sector Erase Sequencer

This block runs the multi-sector erase path of a NOR-style flash command interface. It takes decoded bus writes: a strobe that marks the rising edge of the write enable, an 8-bit command code, a sector index, a word offset and a data byte. A sector erase command in read mode opens an accept window. More sector erase commands can arrive while the window is open. Each one adds its sector to a pending bitmap and starts the window over. When the window runs out, the block runs its own erase. Each pending sector, lowest index first, is written to all zeros, read back to verify the zeros, and then set to all ones. The block then returns to read mode.

A stub array holds the sector contents. In read mode the host can load this array with a program command, and it can always read the array through a separate registered read port. Three registered status outputs are provided: `busy`, `win_closed` and a one-cycle `done` pulse. `win_closed` is low while sectors can still be added and high from the moment the window expires until the erase finishes. The synchronous reset is also the hardware reset. It stops an erase on the next edge.

Command codes: sector erase `0x30`, erase suspend `0xB0`, program `0xA0`; any other code is a foreign command. `NUM_SECTORS` and `SECTOR_WORDS` are powers of two, and the array address is `{sector, offset}`.

Top module: `flash_sector_erase_seq`

## Requirements
- R1: In read mode, a strobe carrying command `0xA0` writes `wr_data` to word `wr_offset` of sector `wr_sector`. `rd_data` shows the word at `{rd_sector, rd_offset}` one clock after that address is presented.
- R2: After reset, `busy`, `win_closed` and `done` are 0. A sector erase command (`0x30`) in read mode sets `busy` to 1 and keeps `win_closed` at 0 after the same edge.
- R3: Each sector erase command accepted while the window is open adds its sector to the erase set, in any order. The set may hold any number of sectors, from one to all of them.
- R4: The window closes `WIN_CYCLES` edges after the last accepted sector erase command. `win_closed` stays 0 through edge `WIN_CYCLES-1` and becomes 1 on edge `WIN_CYCLES`.
- R5: A sector erase command sampled `WIN_CYCLES-1` edges after the last accepted one is accepted and restarts the window. One sampled exactly `WIN_CYCLES` edges after it is ignored, and that sector keeps its data.
- R6: Any command other than `0x30` or `0xB0` while the window is open drops the erase set. `busy` and `win_closed` are 0 after that edge, `done` does not pulse, and no sector changes.
- R7: The suspend code `0xB0` inside the window does not cancel the operation. The erase then runs as normal.
- R8: Every word of each selected sector is written to `0x00` and read back as zero before the sector is set to `0xFF`. Sectors that were not selected are not touched.
- R9: Pending sectors are processed in ascending index order, whatever order they were added in.
- R10: Once the window has closed, every command is ignored until the erase completes, including program, sector erase and foreign codes.
- R11: Reset during an erase sets `busy` and `win_closed` to 0 after that edge. Sectors not yet reached keep their data, and the unfinished sector is left partly processed.
- R12: When the last sector finishes, `busy` and `win_closed` fall and `done` is 1 for exactly one cycle. Every word of every erased sector then reads `0xFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also aborts an erase |
| wr_stb | input | 1 | One-cycle pulse marking a decoded bus write |
| wr_cmd | input | 8 | Command code of the write |
| wr_sector | input | SEC_W | Sector index of the write |
| wr_offset | input | OFF_W | Word offset for the program command |
| wr_data | input | DATA_W | Data for the program command |
| rd_sector | input | SEC_W | Sector index of the host read |
| rd_offset | input | OFF_W | Word offset of the host read |
| rd_data | output | DATA_W | Registered host read data |
| busy | output | 1 | Window open or erase running |
| win_closed | output | 1 | Accept window expired, erase in progress |
| done | output | 1 | One-cycle pulse when an erase completes |

## Verification
The two hardest points to reach from the ports are the window's last cycle and a reset between sectors. For the first, the bench counts edges from the previous accepted command. It then places one sector erase command on the final open edge and another on the expiry edge, and checks which sector comes out erased. For the second, the bench adds a high sector before a low one and polls the low sector's first word until it passes through `0x00` and reaches `0xFF`. It then resets at once and checks that the high sector still holds its data and that the low sector's last word is zero but not yet erased.

// File: rtl/fses_pkg.sv
`timescale 1ns/1ps
package fses_pkg;
  localparam logic [7:0] CMD_SECTOR_ERASE  = 8'h30;
  localparam logic [7:0] CMD_ERASE_SUSPEND = 8'hB0;
  localparam logic [7:0] CMD_PROGRAM       = 8'hA0;

  typedef enum logic [2:0] {
    ST_READ,
    ST_WINDOW,
    ST_PREP,
    ST_VERIFY,
    ST_ERASE
  } seq_state_t;
endpackage

// File: rtl/fses_window_timer.sv
`timescale 1ns/1ps
module fses_window_timer #(
  parameter int WIN_CYCLES = 12500
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic active,
  output logic expire
);
  localparam int CW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (active && (cnt_q != LAST)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = active && (cnt_q == LAST);
endmodule

// File: rtl/fses_lowest_pick.sv
`timescale 1ns/1ps
module fses_lowest_pick #(
  parameter int NUM = 8,
  parameter int IW  = $clog2(NUM)
) (
  input  logic [NUM-1:0] req,
  output logic [IW-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/fses_array.sv
`timescale 1ns/1ps
module fses_array #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_a <= mem[raddr_a];
    rdata_b <= mem[raddr_b];
  end
endmodule

// File: rtl/flash_sector_erase_seq.sv
`timescale 1ns/1ps
module flash_sector_erase_seq #(
  parameter int NUM_SECTORS  = 8,
  parameter int SECTOR_WORDS = 16,
  parameter int DATA_W       = 8,
  parameter int WIN_CYCLES   = 12500,
  parameter int SEC_W        = $clog2(NUM_SECTORS),
  parameter int OFF_W        = $clog2(SECTOR_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [7:0]        wr_cmd,
  input  logic [SEC_W-1:0]  wr_sector,
  input  logic [OFF_W-1:0]  wr_offset,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SEC_W-1:0]  rd_sector,
  input  logic [OFF_W-1:0]  rd_offset,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              win_closed,
  output logic              done
);
  import fses_pkg::*;

  localparam int AW = SEC_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST_W = OFF_W'(SECTOR_WORDS - 1);

  seq_state_t             state_q, state_d;
  logic [NUM_SECTORS-1:0] pend_q, pend_d, rest_mask;
  logic [SEC_W-1:0]       cur_q, cur_d, first_idx, next_idx;
  logic [OFF_W-1:0]       widx_q, widx_d;
  logic                   rvld_q, rvld_d, drain_q, drain_d, done_d;
  logic                   restart, win_expire;
  logic                   mem_we;
  logic [AW-1:0]          mem_waddr, eng_raddr;
  logic [DATA_W-1:0]      mem_wdata, eng_rdata;
  logic                   is_se, is_prog, is_susp;

  assign is_se   = wr_stb && (wr_cmd == CMD_SECTOR_ERASE);
  assign is_prog = wr_stb && (wr_cmd == CMD_PROGRAM);
  assign is_susp = wr_stb && (wr_cmd == CMD_ERASE_SUSPEND);
  assign rest_mask = pend_q & ~(NUM_SECTORS'(1) << cur_q);

  fses_window_timer #(.WIN_CYCLES(WIN_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .restart(restart),
    .active(state_q == ST_WINDOW), .expire(win_expire)
  );

  fses_lowest_pick #(.NUM(NUM_SECTORS), .IW(SEC_W)) u_pick_first (
    .req(pend_q), .idx(first_idx)
  );

  fses_lowest_pick #(.NUM(NUM_SECTORS), .IW(SEC_W)) u_pick_next (
    .req(rest_mask), .idx(next_idx)
  );

  fses_array #(.DEPTH(NUM_SECTORS * SECTOR_WORDS), .DW(DATA_W), .AW(AW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr_a({rd_sector, rd_offset}), .rdata_a(rd_data),
    .raddr_b(eng_raddr), .rdata_b(eng_rdata)
  );

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    cur_d     = cur_q;
    widx_d    = widx_q;
    rvld_d    = 1'b0;
    drain_d   = drain_q;
    done_d    = 1'b0;
    restart   = 1'b0;
    mem_we    = 1'b0;
    mem_waddr = {cur_q, widx_q};
    mem_wdata = '0;
    eng_raddr = {cur_q, widx_q};
    case (state_q)
      ST_READ: begin
        if (is_se) begin
          pend_d            = '0;
          pend_d[wr_sector] = 1'b1;
          restart           = 1'b1;
          state_d           = ST_WINDOW;
        end else if (is_prog) begin
          mem_we    = 1'b1;
          mem_waddr = {wr_sector, wr_offset};
          mem_wdata = wr_data;
        end
      end
      ST_WINDOW: begin
        if (win_expire) begin
          state_d = ST_PREP;
          cur_d   = first_idx;
          widx_d  = '0;
        end else if (is_se) begin
          pend_d[wr_sector] = 1'b1;
          restart           = 1'b1;
        end else if (wr_stb && !is_susp) begin
          pend_d  = '0;
          state_d = ST_READ;
        end
      end
      ST_PREP: begin
        mem_we    = 1'b1;
        mem_wdata = '0;
        if (widx_q == LAST_W) begin
          widx_d  = '0;
          drain_d = 1'b0;
          state_d = ST_VERIFY;
        end else begin
          widx_d = widx_q + 1'b1;
        end
      end
      ST_VERIFY: begin
        if (rvld_q && (eng_rdata != '0)) begin
          state_d = ST_PREP;
          widx_d  = '0;
          drain_d = 1'b0;
        end else if (drain_q) begin
          state_d = ST_ERASE;
          widx_d  = '0;
          drain_d = 1'b0;
        end else begin
          rvld_d = 1'b1;
          if (widx_q == LAST_W) drain_d = 1'b1;
          else                  widx_d  = widx_q + 1'b1;
        end
      end
      ST_ERASE: begin
        mem_we    = 1'b1;
        mem_wdata = '1;
        if (widx_q == LAST_W) begin
          pend_d[cur_q] = 1'b0;
          widx_d        = '0;
          if (|rest_mask) begin
            cur_d   = next_idx;
            state_d = ST_PREP;
          end else begin
            state_d = ST_READ;
            done_d  = 1'b1;
          end
        end else begin
          widx_d = widx_q + 1'b1;
        end
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_READ;
      pend_q     <= '0;
      cur_q      <= '0;
      widx_q     <= '0;
      rvld_q     <= 1'b0;
      drain_q    <= 1'b0;
      busy       <= 1'b0;
      win_closed <= 1'b0;
      done       <= 1'b0;
    end else begin
      state_q    <= state_d;
      pend_q     <= pend_d;
      cur_q      <= cur_d;
      widx_q     <= widx_d;
      rvld_q     <= rvld_d;
      drain_q    <= drain_d;
      busy       <= (state_d != ST_READ);
      win_closed <= (state_d == ST_PREP) || (state_d == ST_VERIFY) || (state_d == ST_ERASE);
      done       <= done_d;
    end
  end
endmodule

// File: rtl/fses_checker.sv
`timescale 1ns/1ps
module fses_checker #(
  parameter int NUM_SECTORS = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_stb,
  input logic [7:0]             wr_cmd,
  input logic                   busy,
  input logic                   win_closed,
  input logic                   done,
  input logic [NUM_SECTORS-1:0] pend
);
  import fses_pkg::*;

  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> (!busy && !win_closed && !done));

  assert_window_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !win_closed);

  assert_closed_in_busy_R4: assert property (@(posedge clk) disable iff (rst)
    win_closed |-> busy);

  assert_set_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pend != '0));

  assert_foreign_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !win_closed && wr_stb && (wr_cmd != CMD_SECTOR_ERASE) &&
     (wr_cmd != CMD_ERASE_SUSPEND)) |=> (!busy || win_closed));

  assert_closed_until_end_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(win_closed) |-> !busy);

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_at_read_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(win_closed)));
endmodule

bind flash_sector_erase_seq fses_checker #(.NUM_SECTORS(NUM_SECTORS)) u_fses_checker (
  .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_cmd(wr_cmd),
  .busy(busy), .win_closed(win_closed), .done(done), .pend(pend_q)
);

// File: tb/flash_sector_erase_seq_bench.sv
`timescale 1ns/1ps
module flash_sector_erase_seq_bench;
  localparam int NS  = 8;
  localparam int WW  = 16;
  localparam int DW  = 8;
  localparam int WIN = 64;
  localparam int SW  = 3;
  localparam int OW  = 4;
  localparam logic [7:0] SE = 8'h30, SUSP = 8'hB0, PROG = 8'hA0, FOREIGN = 8'hF0;

  // {sector[14:12], offset[11:8], data[7:0]}
  localparam logic [14:0] VEC [8] = '{
    15'h3011, 15'h4022, 15'h0033, 15'h1044,
    15'h5055, 15'h7077, 15'h205A, 15'h605A
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic [7:0] wr_cmd = '0;
  logic [SW-1:0] wr_sector = '0;
  logic [OW-1:0] wr_offset = '0;
  logic [DW-1:0] wr_data = '0;
  logic [SW-1:0] rd_sector = '0;
  logic [OW-1:0] rd_offset = '0;
  logic [DW-1:0] rd_data;
  logic busy, win_closed, done;
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  flash_sector_erase_seq #(
    .NUM_SECTORS(NS), .SECTOR_WORDS(WW), .DATA_W(DW), .WIN_CYCLES(WIN)
  ) u_flash_sector_erase_seq (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_cmd(wr_cmd),
    .wr_sector(wr_sector), .wr_offset(wr_offset), .wr_data(wr_data),
    .rd_sector(rd_sector), .rd_offset(rd_offset), .rd_data(rd_data),
    .busy(busy), .win_closed(win_closed), .done(done)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [SW-1:0] s,
                      input logic [OW-1:0] o, input logic [DW-1:0] d);
    wr_stb = 1'b1; wr_cmd = c; wr_sector = s; wr_offset = o; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic rd(input logic [SW-1:0] s, input logic [OW-1:0] o,
                    output logic [DW-1:0] d);
    rd_sector = s; rd_offset = o;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    logic saw_zero;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R2", "reset busy", busy, 0);
    chk("R2", "reset win_closed", win_closed, 0);
    chk("R2", "reset done", done, 0);

    // R1: program table then read back
    for (int i = 0; i < 8; i++)
      send(PROG, VEC[i][14:12], VEC[i][11:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][14:12], VEC[i][11:8], v);
      chk("R1", "readback", v, VEC[i][7:0]);
    end

    // R2 R3 R4 R5: descending add on the last open edge
    send(SE, 3'd4, '0, '0);
    chk("R2", "busy after first", busy, 1);
    chk("R2", "win_closed after first", win_closed, 0);
    repeat (WIN - 2) @(negedge clk);
    send(SE, 3'd3, '0, '0);
    repeat (WIN - 1) @(negedge clk);
    chk("R4", "open at edge WIN-1", win_closed, 0);
    chk("R5", "busy after late accept", busy, 1);
    @(negedge clk);
    chk("R4", "closed at edge WIN", win_closed, 1);
    wait_idle();
    chk("R12", "done pulse", done, 1);
    chk("R12", "win_closed at end", win_closed, 0);
    @(negedge clk);
    chk("R12", "done single", done, 0);
    rd(3'd4, 4'd0, v); chk("R3", "sector4 w0", v, 8'hFF);
    rd(3'd3, 4'd0, v); chk("R5", "sector3 w0 accepted", v, 8'hFF);
    rd(3'd3, 4'd15, v); chk("R12", "sector3 w15", v, 8'hFF);

    // R5: command on the expiry edge is ignored
    send(SE, 3'd0, '0, '0);
    repeat (WIN - 1) @(negedge clk);
    send(SE, 3'd1, '0, '0);
    chk("R5", "closed on expiry edge", win_closed, 1);
    wait_idle();
    rd(3'd0, 4'd0, v); chk("R5", "sector0 erased", v, 8'hFF);
    rd(3'd1, 4'd0, v); chk("R5", "sector1 kept", v, 8'h44);

    // R6: foreign command aborts
    send(SE, 3'd5, '0, '0);
    repeat (3) @(negedge clk);
    send(FOREIGN, '0, '0, '0);
    chk("R6", "busy after abort", busy, 0);
    chk("R6", "done after abort", done, 0);
    rd(3'd5, 4'd0, v); chk("R6", "sector5 kept", v, 8'h55);

    // R7: suspend code in window does not cancel
    send(SE, 3'd5, '0, '0);
    repeat (3) @(negedge clk);
    send(SUSP, '0, '0, '0);
    chk("R7", "busy after suspend", busy, 1);
    chk("R7", "window still open", win_closed, 0);
    wait_idle();
    rd(3'd5, 4'd0, v); chk("R7", "sector5 erased", v, 8'hFF);

    // R10: commands ignored while erasing
    send(SE, 3'd6, '0, '0);
    for (int g = 0; g < 500 && !win_closed; g++) @(negedge clk);
    send(PROG, 3'd7, 4'd0, 8'h99);
    send(SE, 3'd7, '0, '0);
    send(FOREIGN, '0, '0, '0);
    chk("R10", "busy kept", busy, 1);
    wait_idle();
    rd(3'd7, 4'd0, v); chk("R10", "sector7 untouched", v, 8'h77);
    rd(3'd6, 4'd0, v); chk("R8", "sector6 erased", v, 8'hFF);

    // R8 R9 R11: high sector added first, reset once low sector is erasing
    send(PROG, 3'd6, 4'd0, 8'h5A);
    send(SE, 3'd6, '0, '0);
    send(SE, 3'd2, '0, '0);
    rd_sector = 3'd2; rd_offset = 4'd0;
    saw_zero = 1'b0;
    for (int g = 0; g < 2000; g++) begin
      @(negedge clk);
      if (rd_data == 8'h00) saw_zero = 1'b1;
      if (rd_data == 8'hFF) break;
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "win_closed after reset", win_closed, 0);
    chk("R8", "zero seen before FF", saw_zero, 1);
    rd(3'd6, 4'd0, v); chk("R9", "higher sector not reached", v, 8'h5A);
    rd(3'd2, 4'd15, v); chk("R11", "unfinished word preprogrammed", v, 8'h00);
    rd(3'd2, 4'd0, v); chk("R9", "lower sector erased first", v, 8'hFF);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule